// File: doc/BRIEF.md
# Double-Buffered PWM Grayscale Engine

This block turns per-channel brightness words into on/off drive signals for a row of LED current sinks. Words arrive on a one-bit serial line, one bit per shift strobe, and a latch line is held high across the last few strobes of a word. The number of strobes seen while the latch line is high forms a command key. Brightness words are collected in a temporary buffer bank, one word for each data-latch key. A global-latch key then copies the whole bank into the active brightness registers in a single cycle, so a new frame never appears half written.

A free-running grayscale counter advances on each PWM tick. A channel drives while its active brightness is greater than the counter, and only if its bit in the switch register is set. A configuration word selects a 16-bit or a 12-bit counter and turns staggered turn-on on or off. It can also arm an automatic sleep that starts when an all-zero switch word is latched. The serial strobe and the PWM tick are both enables on one system clock.

There are two state machines. The key decoder steps `K_IDLE -> K_COUNT` when the latch line rises, `K_COUNT -> K_EXEC` when it falls, and `K_EXEC -> K_IDLE` after its single issue cycle. The power controller steps `P_AWAKE -> P_ASLEEP` on a zero switch write with sleep armed, and `P_ASLEEP -> P_AWAKE` on a nonzero switch write.

Top module: `pwm_gray_engine`

## Requirements
- R1: Each `ser_shift` strobe shifts `ser_data` into the word, most significant bit first. A command executes after `ser_latch` falls and uses the count of strobes that were seen while `ser_latch` was high. A count of 1 or 2 writes the switch register, 3 or 4 is a data latch, 5 or 6 is a global latch, and 7 writes the configuration. Any other count does nothing.
- R2: A data latch stores the word in the temporary buffer at the current index and then decrements the index. The index starts at 15, so the first word is for channel 15. The outputs do not change until a global latch.
- R3: A global latch writes its own word to channel 0 and, in the same cycle, copies buffers 15..1 into the active registers. It then sets the index back to 15.
- R4: In wide mode, channel i is on while its brightness is greater than the counter. The counter rises by one per `pwm_tick` and wraps from 65535 to 0.
- R5: With configuration bit 15 set (narrow mode), the counter wraps from 4095 to 0 and the top four bits of each brightness word are ignored.
- R6: After reset, the brightness, the switch register, the configuration and the counter are all zero, and every output is off.
- R7: With bit 14 set, a channel with committed nonzero brightness and its switch bit on drives before any `pwm_tick`.
- R8: Every output is its compare result ANDed with its switch bit.
- R9: With bit 14 clear, channel i shows its compare result delayed by i ticks, and channel 0 has no delay. With bit 14 set, no channel is delayed.
- R10: With bit 10 set, a switch write of zero puts the block to sleep. While asleep the outputs are off, the counter and the delay lines are held at zero, and data latches, global latches and configuration writes are ignored. A nonzero switch write wakes the block and is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_shift | input | 1 | Serial bit strobe |
| ser_data | input | 1 | Serial data bit |
| ser_latch | input | 1 | Latch line that forms the command key |
| pwm_tick | input | 1 | Grayscale counter advance strobe |
| led_on | output | 16 | Per-channel drive, registered |

## Verification
The bench goes after the counter wrap in both widths. A 12-bit counter that kept carrying into bit 12 would leave channels with large top nibbles lit after the 4096th tick. It checks that loaded data stays invisible before the global commit, which a single-level store would break. It watches a lit channel walk from channel 0 upward one tick at a time, which catches a stagger line that is missing, reversed or one tick off. In sleep it sends new brightness and a new configuration and, after wake, looks for outputs that would only appear if either had been accepted.

// File: rtl/pge_pkg.sv
package pge_pkg;
    localparam int PGE_NCH      = 16;
    localparam int PGE_WORD_W   = 16;
    localparam int PGE_NARROW_W = 12;
    localparam int PGE_KEY_W    = 4;

    // configuration bit positions
    localparam int CFG_NARROW    = 15;
    localparam int CFG_NOSTAGGER = 14;
    localparam int CFG_AUTOSLEEP = 10;

    typedef enum logic [1:0] {K_IDLE, K_COUNT, K_EXEC} key_state_e;
    typedef enum logic {P_AWAKE, P_ASLEEP} pwr_state_e;
    typedef enum logic [2:0] {
        CMD_NONE, CMD_SWITCH, CMD_DLATCH, CMD_GLATCH, CMD_CFG
    } cmd_e;
endpackage

// File: rtl/pge_key_decoder.sv
module pge_key_decoder
    import pge_pkg::*;
#(
    parameter int WORD_W = PGE_WORD_W,
    parameter int KEY_W  = PGE_KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdi,
    input  logic              latch_en,
    output cmd_e              cmd,
    output logic [WORD_W-1:0] word
);
    localparam logic [KEY_W-1:0] EDGE_MAX = '1;

    key_state_e       st, st_nx;
    logic [KEY_W-1:0] edges;
    logic [WORD_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= K_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            K_IDLE:  if (latch_en)  st_nx = K_COUNT;
            K_COUNT: if (!latch_en) st_nx = K_EXEC;
            K_EXEC:  st_nx = K_IDLE;
            default: st_nx = K_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            edges <= '0;
        else if (st == K_EXEC)
            edges <= '0;
        else if (shift_en && latch_en && edges != EDGE_MAX)
            edges <= edges + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        sreg <= '0;
        else if (shift_en) sreg <= {sreg[WORD_W-2:0], sdi};
    end

    always_comb begin
        cmd = CMD_NONE;
        if (st == K_EXEC) begin
            unique case (edges)
                KEY_W'(1), KEY_W'(2): cmd = CMD_SWITCH;
                KEY_W'(3), KEY_W'(4): cmd = CMD_DLATCH;
                KEY_W'(5), KEY_W'(6): cmd = CMD_GLATCH;
                KEY_W'(7):            cmd = CMD_CFG;
                default:              cmd = CMD_NONE;
            endcase
        end
    end

    assign word = sreg;

    assert_cmd_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NONE) |-> !$past(latch_en));
    assert_cmd_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NONE) |=> (cmd == CMD_NONE));
endmodule

// File: rtl/pge_ctrl.sv
module pge_ctrl
    import pge_pkg::*;
#(
    parameter int NCH = PGE_NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  cmd_e           cmd,
    input  logic [NCH-1:0] sw_word,
    input  logic           narrow_in,
    input  logic           nostag_in,
    input  logic           sleep_in,
    output logic [NCH-1:0] sw_q,
    output logic           narrow,
    output logic           no_stagger,
    output logic           awake,
    output logic           do_dlatch,
    output logic           do_glatch
);
    pwr_state_e ps, ps_nx;
    logic       autosleep;
    logic       sw_wr, sw_zero, cfg_wr;

    assign sw_wr   = (cmd == CMD_SWITCH);
    assign sw_zero = (sw_word == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) ps <= P_AWAKE;
        else        ps <= ps_nx;
    end

    always_comb begin
        ps_nx = ps;
        unique case (ps)
            P_AWAKE:  if (sw_wr && sw_zero && autosleep) ps_nx = P_ASLEEP;
            P_ASLEEP: if (sw_wr && !sw_zero)             ps_nx = P_AWAKE;
            default:  ps_nx = P_AWAKE;
        endcase
    end

    always_comb begin
        awake     = 1'b0;
        do_dlatch = 1'b0;
        do_glatch = 1'b0;
        cfg_wr    = 1'b0;
        unique case (ps)
            P_AWAKE: begin
                awake     = 1'b1;
                do_dlatch = (cmd == CMD_DLATCH);
                do_glatch = (cmd == CMD_GLATCH);
                cfg_wr    = (cmd == CMD_CFG);
            end
            P_ASLEEP: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     sw_q <= '0;
        else if (sw_wr) sw_q <= sw_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            narrow     <= 1'b0;
            no_stagger <= 1'b0;
            autosleep  <= 1'b0;
        end else if (cfg_wr) begin
            narrow     <= narrow_in;
            no_stagger <= nostag_in;
            autosleep  <= sleep_in;
        end
    end

    assert_asleep_switch_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |-> (sw_q == '0));
    assert_cfg_frozen_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> ($stable(narrow) && $stable(no_stagger)));
endmodule

// File: rtl/pge_bright_store.sv
module pge_bright_store
    import pge_pkg::*;
#(
    parameter int NCH    = PGE_NCH,
    parameter int WORD_W = PGE_WORD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         do_dlatch,
    input  logic                         do_glatch,
    input  logic [WORD_W-1:0]            word,
    output logic [NCH-1:0][WORD_W-1:0]   level
);
    localparam int IDX_W = $clog2(NCH);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NCH - 1);

    logic [NCH-1:0][WORD_W-1:0] stage_q;
    logic [NCH-1:0][WORD_W-1:0] level_q;
    logic [IDX_W-1:0]           idx;

    always_ff @(posedge clk) begin
        if (!rst_n)         idx <= IDX_TOP;
        else if (do_glatch) idx <= IDX_TOP;
        else if (do_dlatch) idx <= idx - 1'b1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[g] <= '0;
            else if (do_dlatch && idx == IDX_W'(g))
                stage_q[g] <= word;
        end

        if (g == 0) begin : g_direct
            always_ff @(posedge clk) begin
                if (!rst_n)         level_q[g] <= '0;
                else if (do_glatch) level_q[g] <= word;
            end
        end else begin : g_buffered
            always_ff @(posedge clk) begin
                if (!rst_n)         level_q[g] <= '0;
                else if (do_glatch) level_q[g] <= stage_q[g];
            end
        end
    end

    assign level = level_q;

    assert_idx_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_glatch |=> (idx == IDX_TOP));
    assert_level_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !do_glatch |=> $stable(level_q));
endmodule

// File: rtl/pge_pwm_core.sv
module pge_pwm_core
    import pge_pkg::*;
#(
    parameter int NCH      = PGE_NCH,
    parameter int WORD_W   = PGE_WORD_W,
    parameter int NARROW_W = PGE_NARROW_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pwm_tick,
    input  logic                       awake,
    input  logic                       narrow,
    input  logic                       no_stagger,
    input  logic [NCH-1:0]             sw,
    input  logic [NCH-1:0][WORD_W-1:0] level,
    output logic [NCH-1:0]             led
);
    localparam logic [WORD_W-1:0] NMASK =
        {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [WORD_W-1:0] cnt, mask, cnt_eff;
    logic [NCH-1:0]    cmp, delayed;

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!awake)   cnt <= '0;
        else if (pwm_tick) cnt <= narrow ? ((cnt + 1'b1) & NMASK) : (cnt + 1'b1);
    end

    assign mask    = narrow ? NMASK : '1;
    assign cnt_eff = cnt & mask;

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign cmp[g] = (level[g] & mask) > cnt_eff;
    end

    assign delayed[0] = cmp[0];
    for (genvar g = 1; g < NCH; g++) begin : g_stagger
        logic [g-1:0] dl;
        if (g == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n)        dl <= '0;
                else if (!awake)   dl <= '0;
                else if (pwm_tick) dl <= cmp[g];
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n)        dl <= '0;
                else if (!awake)   dl <= '0;
                else if (pwm_tick) dl <= {dl[g-2:0], cmp[g]};
            end
        end
        assign delayed[g] = dl[g-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      led <= '0;
        else if (!awake) led <= '0;
        else             led <= sw & (no_stagger ? cmp : delayed);
    end

    assert_led_within_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (led & ~$past(sw)) == '0);
    assert_narrow_upper_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && pwm_tick && narrow) |=> ((cnt & ~NMASK) == '0));
    assert_wide_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && pwm_tick && !narrow && cnt == '1) |=> (cnt == '0));
    assert_dark_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> (led == '0));
endmodule

// File: rtl/pwm_gray_engine.sv
module pwm_gray_engine
    import pge_pkg::*;
#(
    parameter int NCH      = PGE_NCH,
    parameter int WORD_W   = PGE_WORD_W,
    parameter int NARROW_W = PGE_NARROW_W,
    parameter int KEY_W    = PGE_KEY_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_shift,
    input  logic           ser_data,
    input  logic           ser_latch,
    input  logic           pwm_tick,
    output logic [NCH-1:0] led_on
);
    cmd_e                       cmd;
    logic [WORD_W-1:0]          word;
    logic [NCH-1:0]             sw_q;
    logic                       narrow, no_stagger, awake;
    logic                       do_dlatch, do_glatch;
    logic [NCH-1:0][WORD_W-1:0] level;

    pge_key_decoder #(.WORD_W(WORD_W), .KEY_W(KEY_W)) u_key (
        .clk(clk), .rst_n(rst_n), .shift_en(ser_shift), .sdi(ser_data),
        .latch_en(ser_latch), .cmd(cmd), .word(word)
    );

    pge_ctrl #(.NCH(NCH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .sw_word(word[NCH-1:0]),
        .narrow_in(word[CFG_NARROW]), .nostag_in(word[CFG_NOSTAGGER]),
        .sleep_in(word[CFG_AUTOSLEEP]), .sw_q(sw_q), .narrow(narrow),
        .no_stagger(no_stagger), .awake(awake), .do_dlatch(do_dlatch),
        .do_glatch(do_glatch)
    );

    pge_bright_store #(.NCH(NCH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .do_dlatch(do_dlatch), .do_glatch(do_glatch),
        .word(word), .level(level)
    );

    pge_pwm_core #(.NCH(NCH), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_core (
        .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .awake(awake),
        .narrow(narrow), .no_stagger(no_stagger), .sw(sw_q), .level(level),
        .led(led_on)
    );
endmodule

// File: tb/sim_pwm_gray_engine.sv
module sim_pwm_gray_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_shift = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_latch = 1'b0;
    logic        pwm_tick = 1'b0;
    logic [15:0] led_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    logic [15:0] bright_m [16];
    logic [15:0] sw_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_gray_engine u0 (
        .clk(clk), .rst_n(rst_n), .ser_shift(ser_shift), .ser_data(ser_data),
        .ser_latch(ser_latch), .pwm_tick(pwm_tick), .led_on(led_on)
    );

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (led_on !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, led_on, it.exp);
                end
            end
        end
    end

    task automatic expect_led(input logic [15:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    // reference from the requirements: on when masked brightness > count, gated by switch
    function automatic logic [15:0] model(input int k, input bit nar);
        logic [15:0] v;
        for (int i = 0; i < 16; i++) begin
            logic [15:0] b;
            b = nar ? (bright_m[i] & 16'h0FFF) : bright_m[i];
            v[i] = (32'(b) > k) && sw_m[i];
        end
        return v;
    endfunction

    task automatic ser_cmd(input logic [15:0] w, input int key);
        for (int b = 15; b >= 0; b--) begin
            @(posedge clk); #1;
            ser_data  = w[b];
            ser_shift = 1'b1;
            ser_latch = (b < key);
        end
        @(posedge clk); #1;
        ser_shift = 1'b0;
        ser_latch = 1'b0;
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        pwm_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        pwm_tick = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic load_upper();
        for (int ch = 15; ch >= 1; ch--)
            ser_cmd(bright_m[ch], (ch % 2 == 0) ? 3 : 4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        expect_led(16'h0000, "R6 reset outputs off");

        // wide mode, stagger off
        ser_cmd(16'h4000, 7);
        ser_cmd(16'hFFFF, 1);
        sw_m = 16'hFFFF;
        for (int i = 0; i < 16; i++) bright_m[i] = 16'(i);
        load_upper();
        expect_led(16'h0000, "R2 buffered words not yet visible");
        ser_cmd(bright_m[0], 5);
        expect_led(model(0, 0), "R3 R7 global commit lights at count 0");

        ser_cmd(16'hFFFF, 9);
        ser_cmd(16'h0000, 8);
        expect_led(model(0, 0), "R1 unknown key counts do nothing");

        ticks(3);
        expect_led(model(3, 0), "R4 compare at count 3");

        ser_cmd(16'h00FF, 2);
        sw_m = 16'h00FF;
        expect_led(model(3, 0), "R8 switch gating");

        ticks(65532);
        expect_led(model(65535, 0), "R4 count 65535");
        ticks(1);
        expect_led(model(0, 0), "R4 wide wrap to 0");

        // narrow mode
        ser_cmd(16'hC000, 7);
        ser_cmd(16'hFFFF, 1);
        sw_m = 16'hFFFF;
        for (int i = 0; i < 16; i++) bright_m[i] = 16'hF000 | 16'(i);
        load_upper();
        ser_cmd(bright_m[0], 6);
        expect_led(model(0, 1), "R5 upper nibble ignored at count 0");
        ticks(4095);
        expect_led(model(4095, 1), "R5 count 4095");
        ticks(1);
        expect_led(model(0, 1), "R5 narrow wrap to 0");

        // staggered turn-on, narrow
        ser_cmd(16'h8000, 7);
        for (int i = 0; i < 16; i++) bright_m[i] = 16'h0001;
        load_upper();
        ser_cmd(bright_m[0], 5);
        ticks(4096);
        expect_led(16'h0001, "R9 channel 0 undelayed");
        ticks(1);
        expect_led(16'h0002, "R9 channel 1 one tick late");
        ticks(1);
        expect_led(16'h0004, "R9 channel 2 two ticks late");
        ticks(13);
        expect_led(16'h8000, "R9 channel 15 fifteen ticks late");

        // auto sleep
        ser_cmd(16'hC400, 7);
        ser_cmd(16'h0000, 1);
        sw_m = 16'h0000;
        expect_led(16'h0000, "R10 asleep outputs off");
        ticks(5);
        for (int ch = 15; ch >= 1; ch--) ser_cmd(16'h0FFF, 3);
        ser_cmd(16'h0FFF, 5);
        ser_cmd(16'h0000, 7);
        ser_cmd(16'h0F0F, 1);
        sw_m = 16'h0F0F;
        expect_led(model(0, 1), "R10 wake latches switch and count held at 0");
        ticks(1);
        expect_led(model(1, 1), "R10 loads and config ignored while asleep");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule